// File: doc/BRIEF.md
# Word-to-Bit Serializer with Load-Phase Realignment

This block turns a stream of parallel words into a single serial bit stream. Each word arrives on a slow word clock and is caught in a holding register on that clock's rising edge. A load strobe runs at word rate but is made in the fast bit-clock domain. It copies the held word into a shift register, which then sends the word out one bit per bit-clock cycle, most significant bit first.

The two clocks are locked to each other at a 1:W ratio (W is 16 by default), but their relative phase is arbitrary. A phase-initialization input lets the surrounding logic move the load point. A rising edge on that input, seen in the bit domain, restarts the load counter so that the next transfer lands a fixed number of bit times later. By default this is half a word, which puts the transfer in the middle of the window where the held word is stable. A synchronous active-low reset clears the holding register, the load counter and the shift register.

Top module: `word_serializer`

## Requirements
- R1: The holding register takes `par_data` on each rising edge of `clk_word` while `rst_n` is high, and the word held there is the one the next transfer sends.
- R2: With no phase-init edge, transfers recur every W bit-clock edges, so every held word is sent exactly once, with no word dropped and none repeated.
- R3: On the bit edge that performs a transfer, `ser_out` takes bit W-1 of the held word. Each later bit edge moves it one bit position lower, so bit 0 is sent last.
- R4: If a rising edge of `phase_init` is sampled at bit edge k, the next transfer happens at bit edge k+ALIGN (ALIGN is 8 by default). After that, transfers return to every W edges.
- R5: A `phase_init` level that is held high, or that falls, does not change the transfer timing.
- R6: While `rst_n` is low at bit-clock edges, `ser_out` is 0 from the first such edge onward.
- R7: After `rst_n` goes high, `ser_out` stays 0 until the first transfer. Without a phase-init edge, that transfer happens at the W-th bit edge sampled with `rst_n` high.
- R8: If a phase-init rising edge is sampled on the same bit edge as a scheduled transfer, that transfer still takes place, and the next one follows ALIGN edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock; drives the load counter and the shift register |
| clk_word | input | 1 | Word-rate clock, locked at 1:W to `clk_bit` |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| par_data | input | W | Parallel input word, stable around the rising edge of `clk_word` |
| phase_init | input | 1 | Realignment request; only its rising edge in the bit domain counts |
| ser_out | output | 1 | Serial data, most significant bit first |

## Verification
The checker assumes three things. First, the two clocks keep an exact 1:W ratio, and no `clk_word` edge falls on a `clk_bit` edge, so the held word is never caught while it is changing. Second, `phase_init` is synchronous to `clk_bit`. Third, reset stays low across at least one `clk_word` edge. The stimulus meets these by generating both clocks from fixed delays that keep `clk_word` edges 2 ns off every `clk_bit` edge, by driving `par_data` only on `clk_word` falling edges, and by driving `phase_init` and `rst_n` only on `clk_bit` falling edges. The phase-init sweep places the rising edge at every offset from a scheduled transfer, including the offset where the two coincide.

// File: rtl/ws_pkg.sv
// Package: shared constants and helpers for the word serializer.
// Assumes: widths are small positive integers.
package ws_pkg;

    // Default word width (bits per word and bit edges per transfer)
    localparam int unsigned WS_DEF_W = 16;

    // Counter width able to hold values 0..n-1, never below one bit
    function automatic int unsigned ws_cnt_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ws_hold_reg.sv
// Module: ws_hold_reg
// Captures the parallel input word on the word clock and holds it for the
// bit-domain load. Assumes par_data is stable around each clk_word rising edge.
module ws_hold_reg #(
    parameter int unsigned W = ws_pkg::WS_DEF_W
) (
    input  logic         clk_word,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture one word per word-clock edge; clear on reset
    always_ff @(posedge clk_word) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/ws_load_timer.sv
// Module: ws_load_timer
// Makes the word-rate load strobe in the bit domain. A rising edge on
// phase_init presets the counter so that the next strobe comes ALIGN edges
// later. Assumes phase_init is synchronous to clk_bit.
module ws_load_timer #(
    parameter int unsigned W     = ws_pkg::WS_DEF_W,
    parameter int unsigned ALIGN = W / 2
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic phase_init,
    output logic load_stb
);

    localparam int unsigned    CW     = ws_pkg::ws_cnt_w(W);
    localparam logic [CW-1:0] TERM   = CW'(W - 1);
    localparam logic [CW-1:0] PRESET = CW'(W - ALIGN);

    logic          pinit_q;
    logic          pinit_rise;
    logic [CW-1:0] cnt;

    // Edge detector for the realignment request
    assign pinit_rise = phase_init & ~pinit_q;

    // Strobe is active during the last count of each word period
    assign load_stb = (cnt == TERM);

    // Remember the last phase_init level
    always_ff @(posedge clk_bit) begin
        if (!rst_n) pinit_q <= 1'b0;
        else        pinit_q <= phase_init;
    end

    // Free-running word-period counter with realignment preset
    always_ff @(posedge clk_bit) begin
        if (!rst_n)          cnt <= '0;
        else if (pinit_rise) cnt <= PRESET;
        else if (load_stb)   cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ws_shift_out.sv
// Module: ws_shift_out
// Parallel-to-serial shift register. It loads the held word on load_stb and
// otherwise shifts toward the MSB, filling with zeros. Output is the MSB.
// Assumes hold_word is stable at every clk_bit edge where load_stb is high.
module ws_shift_out #(
    parameter int unsigned W = ws_pkg::WS_DEF_W
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] hold_word,
    output logic         ser_out
);

    logic [W-1:0] sreg;
    logic [W-1:0] sreg_nxt;

    // Next-state value per bit: load, or take the lower neighbour
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign sreg_nxt[i] = load_stb ? hold_word[i] : 1'b0;
        end else begin : g_upper
            assign sreg_nxt[i] = load_stb ? hold_word[i] : sreg[i-1];
        end
    end

    // Shift register state
    always_ff @(posedge clk_bit) begin
        if (!rst_n) sreg <= '0;
        else        sreg <= sreg_nxt;
    end

    assign ser_out = sreg[W-1];

endmodule

// File: rtl/word_serializer.sv
// Module: word_serializer (top)
// Word-to-bit serializer: a holding register on clk_word, a load strobe
// timer and a shift register on clk_bit. Assumes clk_word is locked to
// clk_bit at 1:W with edges that never coincide.
module word_serializer #(
    parameter int unsigned W     = ws_pkg::WS_DEF_W,
    parameter int unsigned ALIGN = W / 2
) (
    input  logic         clk_bit,
    input  logic         clk_word,
    input  logic         rst_n,
    input  logic [W-1:0] par_data,
    input  logic         phase_init,
    output logic         ser_out
);

    logic [W-1:0] hold_word;
    logic         load_stb;

    // Word-domain capture
    ws_hold_reg #(.W(W)) u_hold (
        .clk_word (clk_word),
        .rst_n    (rst_n),
        .d        (par_data),
        .q        (hold_word)
    );

    // Bit-domain load timing
    ws_load_timer #(.W(W), .ALIGN(ALIGN)) u_timer (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .phase_init (phase_init),
        .load_stb   (load_stb)
    );

    // Serial output stage
    ws_shift_out #(.W(W)) u_shift (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .hold_word (hold_word),
        .ser_out   (ser_out)
    );

endmodule

// File: rtl/ws_checker.sv
// Module: ws_checker
// Property checker bound into word_serializer. It keeps its own expected
// countdown to the next transfer and checks strobe timing and output order.
// Assumes phase_init is synchronous to clk_bit.
module ws_checker #(
    parameter int unsigned W     = ws_pkg::WS_DEF_W,
    parameter int unsigned ALIGN = W / 2
) (
    input logic clk_bit,
    input logic rst_n,
    input logic phase_init,
    input logic load_stb,
    input logic hold_msb,
    input logic ser_out
);

    localparam int unsigned CW = ws_pkg::ws_cnt_w(W);

    logic          pq;
    logic [CW-1:0] left;
    logic          primed;
    logic          rst_q;

    // Expected edges remaining until the next transfer
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            pq     <= 1'b0;
            left   <= CW'(W - 1);
            primed <= 1'b0;
        end else begin
            pq <= phase_init;
            if (phase_init && !pq) left <= CW'(ALIGN - 1);
            else if (left == '0)   left <= CW'(W - 1);
            else                   left <= left - 1'b1;
            if (load_stb) primed <= 1'b1;
        end
    end

    // Reset level seen at the last edge
    always_ff @(posedge clk_bit) rst_q <= rst_n;

    AST_LOAD_SPACING: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (left == '0) |-> load_stb);                                   // R2
    AST_LOAD_SCHEDULED: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_stb |-> (left == '0));                                   // R4
    AST_MSB_FIRST: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_stb |=> (ser_out == $past(hold_msb)));                   // R3
    AST_QUIET_BEFORE_LOAD: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !primed |-> (ser_out == 1'b0));                               // R7

    // Output cleared after any edge sampled in reset
    always @(negedge clk_bit) begin
        if (rst_q === 1'b0) begin
            AST_RESET_CLEAR: assert (ser_out == 1'b0);                // R6
        end
    end

endmodule

bind word_serializer ws_checker #(.W(W), .ALIGN(ALIGN)) u_ws_checker (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .phase_init (phase_init),
    .load_stb   (load_stb),
    .hold_msb   (hold_word[W-1]),
    .ser_out    (ser_out)
);

// File: tb/test_word_serializer.sv
module test_word_serializer;

    localparam int W     = 16;
    localparam int ALIGN = 8;

    logic         clk_bit;
    logic         clk_word;
    logic         rst_n;
    logic [W-1:0] par_data;
    logic         phase_init;
    logic         ser_out;

    int    checks   = 0;
    int    failures = 0;
    int    edge_idx = 0;
    int    next_load;
    int    word_no  = 0;
    bit    done     = 0;
    string tag      = "R6";

    logic [W-1:0] m_hold;
    logic [W-1:0] m_sreg;
    logic         m_pprev;

    word_serializer #(.W(W), .ALIGN(ALIGN)) i_word_serializer (
        .clk_bit    (clk_bit),
        .clk_word   (clk_word),
        .rst_n      (rst_n),
        .par_data   (par_data),
        .phase_init (phase_init),
        .ser_out    (ser_out)
    );

    // 125 MHz bit clock: rising edges at 4 + 8n ns
    initial begin
        clk_bit = 1'b0;
        forever #4 clk_bit = ~clk_bit;
    end

    // Word clock at 1/16 rate, rising edges at 2 + 128n ns
    initial begin
        clk_word = 1'b0;
        #2;
        forever begin
            clk_word = 1'b1; #64;
            clk_word = 1'b0; #64;
        end
    end

    // Word source: fixed corner patterns first, then random words
    initial begin
        par_data = '0;
        forever begin
            @(negedge clk_word);
            case (word_no)
                0: par_data = 16'h8000;
                1: par_data = 16'h0001;
                2: par_data = 16'hFFFF;
                3: par_data = 16'h0000;
                4: par_data = 16'hAAAA;
                5: par_data = 16'h5555;
                default: par_data = W'($urandom);
            endcase
            word_no++;
        end
    end

    // Expected holding register, per R1
    always @(posedge clk_word) m_hold <= rst_n ? par_data : '0;

    // One bit-clock cycle: drive at the falling edge, update the model at
    // the rising edge, and compare ser_out 1 ns later
    task automatic step(input logic rst_v, input logic pin_v);
        @(negedge clk_bit);
        rst_n      = rst_v;
        phase_init = pin_v;
        @(posedge clk_bit);
        edge_idx++;
        if (!rst_n) begin
            m_sreg    = '0;
            m_pprev   = 1'b0;
            next_load = edge_idx + W;
        end else begin
            if (edge_idx == next_load) begin
                m_sreg    = m_hold;
                next_load = next_load + W;
            end else begin
                m_sreg = m_sreg << 1;
            end
            if (phase_init && !m_pprev) next_load = edge_idx + ALIGN;
            m_pprev = phase_init;
        end
        #1;
        checks++;
        if (ser_out !== m_sreg[W-1]) begin
            failures++;
            $display("FAIL %s edge=%0d ser_out actual=%0b expected=%0b",
                     tag, edge_idx, ser_out, m_sreg[W-1]);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(100000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        phase_init = 1'b0;
        m_sreg     = '0;
        m_pprev    = 1'b0;
        next_load  = W;

        // R6: output cleared during reset
        tag = "R6";
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);

        // R7: quiet until the first transfer at the W-th edge
        tag = "R7";
        for (int i = 0; i < 24; i++) step(1'b1, 1'b0);

        // R1, R2, R3: steady stream, MSB first, every word once
        tag = "R1/R2/R3";
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0);

        // R4, R8, R5: sweep the phase-init edge over every offset
        for (int off = 0; off < W; off++) begin
            tag = "R2";
            while ((next_load - (edge_idx + 1)) != off) step(1'b1, 1'b0);
            tag = (off == 0) ? "R8" : "R4";
            step(1'b1, 1'b1);
            for (int i = 0; i < ALIGN + 2; i++) step(1'b1, 1'b1);
            tag = "R5";
            for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
            for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        end

        // R6: reset in mid-stream clears the output
        tag = "R6";
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
        tag = "R7";
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule